// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. A board tester drives a test clock, a mode-select line and a serial data input. An optional active-low asynchronous reset is also available. The controller walks the sixteen-state test state machine and keeps a 3-bit instruction. It returns serial data on a test output that is driven only while shifting. The instruction picks one of three data paths between the serial input and the serial output:

- a single-stage bypass register;
- a 32-bit identification register;
- the external boundary-scan chain.

The chain itself sits outside the block. It receives a select line, capture, shift and update strobes, and the serial input. Its serial output comes back into the block. Three mode lines tell the pin logic what to do:

- drive the pins from the chain's update latches;
- drive the core inputs from those latches;
- disable every output.

States: Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, Select-IR-Scan, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR.

Transitions on a rising clock edge, written as TMS=0 / TMS=1:
- Test-Logic-Reset: Run-Test/Idle / Test-Logic-Reset
- Run-Test/Idle: Run-Test/Idle / Select-DR-Scan
- Select-DR-Scan: Capture-DR / Select-IR-Scan
- Capture-DR and Shift-DR: Shift-DR / Exit1-DR
- Exit1-DR: Pause-DR / Update-DR
- Pause-DR: Pause-DR / Exit2-DR
- Exit2-DR: Shift-DR / Update-DR
- Update-DR and Update-IR: Run-Test/Idle / Select-DR-Scan
- Select-IR-Scan: Capture-IR / Test-Logic-Reset
- The IR column mirrors the DR column.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low, the controller is in Test-Logic-Reset. The instruction is 3'b011 (IDCODE), and tdo and tdo_oe are both 0.
- R2: From any state, five rising edges with tms high bring the controller to Test-Logic-Reset.
- R3: On every rising edge taken in Test-Logic-Reset, the instruction register loads 3'b011.
- R4: The state machine follows the sixteen-state transition table given above.
- R5: In Capture-IR, the instruction shift stage loads 3'b001. Each Shift-IR edge moves tdi into bit 2, and bit 0 is the bit that reaches tdo. Update-IR copies the shift stage into the instruction.
- R6: The opcodes are:
  - 000 EXTEST
  - 001 INTEST
  - 010 SAMPLE
  - 011 IDCODE
  - 100 HIGHZ
  - 110 CLAMP
  - 111 BYPASS

  Opcode 101 behaves exactly like BYPASS.
- R7: Exactly one data path is selected at any time:
  - the chain for EXTEST, INTEST and SAMPLE;
  - identification for IDCODE;
  - bypass for every other opcode.
- R8: The bypass stage captures 0 in Capture-DR and takes tdi on each Shift-DR edge. Data therefore leaves tdo one clock later.
- R9: The identification register captures ID_VALUE (default 32'h0B5CE02F) in Capture-DR. It shifts least significant bit first, with tdi entering at bit 31.
- R10: chain_sel is high exactly for the chain instructions. chain_capture, chain_shift and chain_update are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while chain_sel is high. chain_si follows tdi. In Shift-DR with the chain selected, tdo carries chain_so.
- R11: The mode lines are set as follows:
  - pin_drive_en is high for EXTEST and CLAMP;
  - core_drive_en is high for INTEST;
  - pins_off is high for HIGHZ;
  - all three are low for SAMPLE, IDCODE and the bypass opcodes.
- R12: tdo and tdo_oe change on the falling edge of tck. tdo_oe is high only in Shift-IR or Shift-DR, and tdo is 0 whenever tdo_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| chain_sel | output | 1 | Boundary chain is the selected data path |
| chain_capture | output | 1 | Chain capture strobe |
| chain_shift | output | 1 | Chain shift strobe |
| chain_update | output | 1 | Chain update strobe |
| chain_si | output | 1 | Serial data into the chain |
| chain_so | input | 1 | Serial data from the chain |
| pin_drive_en | output | 1 | Pins driven from chain update latches |
| core_drive_en | output | 1 | Core inputs driven from chain update latches |
| pins_off | output | 1 | Global output disable |

## Verification
Two things coincide on the edge that leaves Shift-IR or Shift-DR with tms high. That edge shifts its final data bit, and the same edge moves the controller to Exit1. A single off-by-one would either lose that last bit or shift one bit too many. Every scan in the bench ends this way, and some DR scans also leave through Pause and re-enter Shift. A behavioural model steps the state and the shift contents on each edge and predicts tdo. The instruction loaded at Update-IR and the data seen at tdo show whether the final bit was taken exactly once.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_INTEST  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b011;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b100;
    localparam logic [IR_W-1:0] OP_CLAMP   = 3'b110;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

    // Fixed pattern loaded into the instruction shift stage on capture.
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_SEL_DR   = 4'd2,
        TS_CAP_DR   = 4'd3,
        TS_SHIFT_DR = 4'd4,
        TS_EXIT1_DR = 4'd5,
        TS_PAUSE_DR = 4'd6,
        TS_EXIT2_DR = 4'd7,
        TS_UPD_DR   = 4'd8,
        TS_SEL_IR   = 4'd9,
        TS_CAP_IR   = 4'd10,
        TS_SHIFT_IR = 4'd11,
        TS_EXIT1_IR = 4'd12,
        TS_PAUSE_IR = 4'd13,
        TS_EXIT2_IR = 4'd14,
        TS_UPD_IR   = 4'd15
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS = 2'd0,
        DR_IDENT  = 2'd1,
        DR_CHAIN  = 2'd2
    } dr_path_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_o,
    output logic       in_reset_o,
    output logic       ir_capture_o,
    output logic       ir_shift_o,
    output logic       ir_update_o,
    output logic       dr_capture_o,
    output logic       dr_shift_o,
    output logic       dr_update_o
);

    tap_state_t state_q;
    tap_state_t state_d;

    // State register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= TS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            default:     state_d = TS_RESET;
        endcase
    end

    // Control outputs decoded from the current state.
    always_comb begin
        in_reset_o   = 1'b0;
        ir_capture_o = 1'b0;
        ir_shift_o   = 1'b0;
        ir_update_o  = 1'b0;
        dr_capture_o = 1'b0;
        dr_shift_o   = 1'b0;
        dr_update_o  = 1'b0;
        unique case (state_q)
            TS_RESET:    in_reset_o   = 1'b1;
            TS_CAP_IR:   ir_capture_o = 1'b1;
            TS_SHIFT_IR: ir_shift_o   = 1'b1;
            TS_UPD_IR:   ir_update_o  = 1'b1;
            TS_CAP_DR:   dr_capture_o = 1'b1;
            TS_SHIFT_DR: dr_shift_o   = 1'b1;
            TS_UPD_DR:   dr_update_o  = 1'b1;
            default:     ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            ir_capture,
    input  logic            ir_shift,
    input  logic            ir_update,
    output logic [IR_W-1:0] ir_o,
    output logic            ir_so,
    output dr_path_t        path_o,
    output logic            pin_drive_o,
    output logic            core_drive_o,
    output logic            pins_off_o
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] ir_q;

    // Instruction shift stage and instruction latch.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= IR_CAPTURE_PAT;
            ir_q <= OP_IDCODE;
        end else begin
            if (ir_capture) begin
                sr_q <= IR_CAPTURE_PAT;
            end else if (ir_shift) begin
                sr_q <= {tdi, sr_q[IR_W-1:1]};
            end
            if (in_reset) begin
                ir_q <= OP_IDCODE;
            end else if (ir_update) begin
                ir_q <= sr_q;
            end
        end
    end

    // Instruction decode: data path and pin modes.
    always_comb begin
        path_o       = DR_BYPASS;
        pin_drive_o  = 1'b0;
        core_drive_o = 1'b0;
        pins_off_o   = 1'b0;
        unique case (ir_q)
            OP_EXTEST: begin
                path_o      = DR_CHAIN;
                pin_drive_o = 1'b1;
            end
            OP_INTEST: begin
                path_o       = DR_CHAIN;
                core_drive_o = 1'b1;
            end
            OP_SAMPLE: path_o = DR_CHAIN;
            OP_IDCODE: path_o = DR_IDENT;
            OP_HIGHZ:  pins_off_o = 1'b1;
            OP_CLAMP:  pin_drive_o = 1'b1;
            default:   path_o = DR_BYPASS;
        endcase
    end

    assign ir_o  = ir_q;
    assign ir_so = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0B5C_E02F
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  dr_path_t path,
    input  logic     dr_capture,
    input  logic     dr_shift,
    input  logic     dr_update,
    input  logic     chain_so,
    output logic     dr_so,
    output logic     chain_sel,
    output logic     chain_capture,
    output logic     chain_shift,
    output logic     chain_update
);

    localparam logic [ID_W-1:0] ID_INIT = ID_VALUE[ID_W-1:0];

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            sel_byp;
    logic            sel_id;

    assign sel_byp   = (path == DR_BYPASS);
    assign sel_id    = (path == DR_IDENT);
    assign chain_sel = (path == DR_CHAIN);

    // Bypass stage and identification register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_q  <= ID_INIT;
        end else begin
            if (sel_byp && dr_capture) begin
                byp_q <= 1'b0;
            end else if (sel_byp && dr_shift) begin
                byp_q <= tdi;
            end
            if (sel_id && dr_capture) begin
                id_q <= ID_INIT;
            end else if (sel_id && dr_shift) begin
                id_q <= {tdi, id_q[ID_W-1:1]};
            end
        end
    end

    // Strobes to the external boundary chain.
    assign chain_capture = chain_sel && dr_capture;
    assign chain_shift   = chain_sel && dr_shift;
    assign chain_update  = chain_sel && dr_update;

    // Serial output of the selected data path.
    always_comb begin
        unique case (path)
            DR_IDENT: dr_so = id_q[0];
            DR_CHAIN: dr_so = chain_so;
            default:  dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_tdo.sv
module tap_tdo (
    input  logic tck,
    input  logic trst_n,
    input  logic ir_shift,
    input  logic dr_shift,
    input  logic ir_so,
    input  logic dr_so,
    output logic tdo,
    output logic tdo_oe
);

    // Test output launched on the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (ir_shift) begin
            tdo    <= ir_so;
            tdo_oe <= 1'b1;
        end else if (dr_shift) begin
            tdo    <= dr_so;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0B5C_E02F
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic chain_sel,
    output logic chain_capture,
    output logic chain_shift,
    output logic chain_update,
    output logic chain_si,
    input  logic chain_so,
    output logic pin_drive_en,
    output logic core_drive_en,
    output logic pins_off
);

    tap_state_t      state_w;
    logic            in_reset_w;
    logic            ir_cap_w;
    logic            ir_shift_w;
    logic            ir_upd_w;
    logic            dr_cap_w;
    logic            dr_shift_w;
    logic            dr_upd_w;
    logic [IR_W-1:0] ir_w;
    logic            ir_so_w;
    dr_path_t        path_w;
    logic            dr_so_w;

    tap_fsm u_fsm (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .state_o      (state_w),
        .in_reset_o   (in_reset_w),
        .ir_capture_o (ir_cap_w),
        .ir_shift_o   (ir_shift_w),
        .ir_update_o  (ir_upd_w),
        .dr_capture_o (dr_cap_w),
        .dr_shift_o   (dr_shift_w),
        .dr_update_o  (dr_upd_w)
    );

    tap_ir u_ir (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .in_reset     (in_reset_w),
        .ir_capture   (ir_cap_w),
        .ir_shift     (ir_shift_w),
        .ir_update    (ir_upd_w),
        .ir_o         (ir_w),
        .ir_so        (ir_so_w),
        .path_o       (path_w),
        .pin_drive_o  (pin_drive_en),
        .core_drive_o (core_drive_en),
        .pins_off_o   (pins_off)
    );

    tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck           (tck),
        .trst_n        (trst_n),
        .tdi           (tdi),
        .path          (path_w),
        .dr_capture    (dr_cap_w),
        .dr_shift      (dr_shift_w),
        .dr_update     (dr_upd_w),
        .chain_so      (chain_so),
        .dr_so         (dr_so_w),
        .chain_sel     (chain_sel),
        .chain_capture (chain_capture),
        .chain_shift   (chain_shift),
        .chain_update  (chain_update)
    );

    tap_tdo u_tdo (
        .tck      (tck),
        .trst_n   (trst_n),
        .ir_shift (ir_shift_w),
        .dr_shift (dr_shift_w),
        .ir_so    (ir_so_w),
        .dr_so    (dr_so_w),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    assign chain_si = tdi;

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir,
    input logic            chain_sel,
    input logic            chain_capture,
    input logic            chain_shift,
    input logic            chain_update,
    input logic            pin_drive_en,
    input logic            core_drive_en,
    input logic            pins_off
);

    logic [3:0] edges_q;

    // Edges seen since reset release, saturating.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            edges_q <= 4'd0;
        end else if (edges_q != 4'd15) begin
            edges_q <= edges_q + 4'd1;
        end
    end

    a_r2_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (edges_q >= 4'd5 && tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == TS_RESET));

    a_r3_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET) |=> (ir == OP_IDCODE));

    a_r4_shift_dr_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_SHIFT_DR && !tms) |=> (state == TS_SHIFT_DR));

    a_r4_exit1_ir_to_update: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_EXIT1_IR && tms) |=> (state == TS_UPD_IR));

    a_r10_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({chain_capture, chain_shift, chain_update}));

    a_r10_strobe_needs_sel: assert property (@(posedge tck) disable iff (!trst_n)
        (chain_capture || chain_shift || chain_update) |-> chain_sel);

    a_r11_modes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({pin_drive_en, core_drive_en, pins_off}));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk chk_i (
    .tck           (tck),
    .trst_n        (trst_n),
    .tms           (tms),
    .state         (state_w),
    .ir            (ir_w),
    .chain_sel     (chain_sel),
    .chain_capture (chain_capture),
    .chain_shift   (chain_shift),
    .chain_update  (chain_update),
    .pin_drive_en  (pin_drive_en),
    .core_drive_en (core_drive_en),
    .pins_off      (pins_off)
);

// File: tb/jtag_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_tb_top;

    localparam logic [31:0] ID = 32'h0B5C_E02F;

    logic tck = 1'b0;
    logic trst_n, tms, tdi, chain_so;
    logic tdo, tdo_oe, chain_sel, chain_capture, chain_shift, chain_update, chain_si;
    logic pin_drive_en, core_drive_en, pins_off;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural model state.
    int       m_st;
    bit [2:0] m_ir, m_irsr;
    bit       m_byp;
    bit [31:0] m_id;
    bit       m_tdo, m_oe;

    always #2.5 tck = ~tck;

    jtag_tap_ctrl dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe),
        .chain_sel(chain_sel), .chain_capture(chain_capture),
        .chain_shift(chain_shift), .chain_update(chain_update),
        .chain_si(chain_si), .chain_so(chain_so),
        .pin_drive_en(pin_drive_en), .core_drive_en(core_drive_en), .pins_off(pins_off)
    );

    // State numbers: 0 reset, 1 idle, 2..8 DR column, 9..15 IR column (R4).
    function automatic int nxt(int s, bit t);
        case (s)
            0:  return t ? 0 : 1;
            1:  return t ? 2 : 1;
            2:  return t ? 9 : 3;
            3, 4: return t ? 5 : 4;
            5:  return t ? 8 : 6;
            6:  return t ? 7 : 6;
            7:  return t ? 8 : 4;
            8, 15: return t ? 2 : 1;
            9:  return t ? 0 : 10;
            10, 11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return 0;
        endcase
    endfunction

    // 0 bypass, 1 identification, 2 chain (R7).
    function automatic int path_of(bit [2:0] i);
        if (i <= 3'd2) return 2;
        if (i == 3'd3) return 1;
        return 0;
    endfunction

    task automatic model_reset();
        m_st = 0; m_ir = 3'b011; m_irsr = 3'b001;
        m_byp = 0; m_id = ID; m_tdo = 0; m_oe = 0;
    endtask

    task automatic model_rise(bit t, bit d);
        int p = path_of(m_ir);
        case (m_st)
            10: m_irsr = 3'b001;
            11: m_irsr = {d, m_irsr[2:1]};
            15: m_ir = m_irsr;
            0:  m_ir = 3'b011;
            3: begin
                if (p == 0) m_byp = 0;
                if (p == 1) m_id = ID;
            end
            4: begin
                if (p == 0) m_byp = d;
                if (p == 1) m_id = {d, m_id[31:1]};
            end
            default: ;
        endcase
        m_st = nxt(m_st, t);
    endtask

    task automatic model_fall();
        int p = path_of(m_ir);
        if (m_st == 11) begin
            m_tdo = m_irsr[0]; m_oe = 1;
        end else if (m_st == 4) begin
            m_tdo = (p == 0) ? m_byp : (p == 1) ? m_id[0] : chain_so;
            m_oe = 1;
        end else begin
            m_tdo = 0; m_oe = 0;
        end
    endtask

    task automatic cmp(string tag, string what, logic [3:0] got, logic [3:0] exp);
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b exp %b (state %0d ir %b)", tag, what, got, exp, m_st, m_ir);
        end
    endtask

    task automatic check(string tag);
        int p = path_of(m_ir);
        bit sel = (p == 2);
        vectors++;
        cmp({tag, "/R12"}, "tdo,tdo_oe", {2'b0, tdo, tdo_oe}, {2'b0, m_tdo, m_oe});
        cmp({tag, "/R10"}, "sel,cap,shift,upd",
            {chain_sel, chain_capture, chain_shift, chain_update},
            {sel, sel && m_st == 3, sel && m_st == 4, sel && m_st == 8});
        cmp({tag, "/R10"}, "chain_si", {3'b0, chain_si}, {3'b0, tdi});
        cmp({tag, "/R11"}, "drive,core,off", {1'b0, pin_drive_en, core_drive_en, pins_off},
            {1'b0, (m_ir == 3'b000 || m_ir == 3'b110), (m_ir == 3'b001), (m_ir == 3'b100)});
    endtask

    // Called just after a falling edge.
    task automatic step(bit t, bit d, string tag);
        bit c = 1'($urandom);
        tms = t; tdi = d; chain_so = c;
        @(posedge tck);
        model_rise(t, d);
        @(negedge tck);
        #0.5;
        model_fall();
        check(tag);
    endtask

    task automatic load_ir(bit [2:0] op, string tag);
        step(1, 0, tag); step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
        for (int i = 0; i < 3; i++) step(i == 2, op[i], tag);
        step(1, 0, tag); step(0, 0, tag);
    endtask

    task automatic scan_dr(int n, bit pause, string tag);
        step(1, 0, tag); step(0, 0, tag); step(0, 0, tag);
        for (int i = 0; i < n; i++) begin
            bit last = (i == n - 1) || (pause && i == n / 2);
            step(last, 1'($urandom), tag);
            if (pause && i == n / 2) begin
                step(0, 0, tag); step(0, 0, tag); step(1, 0, tag); step(0, 0, tag);
            end
        end
        step(1, 0, tag); step(0, 0, tag);
    endtask

    initial begin
        trst_n = 0; tms = 1; tdi = 0; chain_so = 0;
        model_reset();
        repeat (3) @(negedge tck);
        #0.5;
        check("R1");
        trst_n = 1;
        step(0, 0, "R4");
        scan_dr(34, 0, "R9");
        for (int op = 0; op < 8; op++) begin
            load_ir(3'(op), "R5");
            check("R6");
            scan_dr(36, op[0], (op <= 2) ? "R10" : (op == 3) ? "R9" : "R8");
        end
        load_ir(3'b101, "R6");
        scan_dr(20, 1, "R7");
        load_ir(3'b111, "R8");
        step(1, 0, "R2"); step(0, 0, "R2"); step(0, 0, "R2"); step(0, 1, "R2");
        for (int i = 0; i < 5; i++) step(1, 0, "R2");
        step(0, 0, "R3");
        scan_dr(33, 0, "R3");
        load_ir(3'b000, "R1");
        step(1, 0, "R1"); step(0, 0, "R1"); step(0, 0, "R1"); step(0, 1, "R1");
        #1 trst_n = 0;
        model_reset();
        #0.5 check("R1");
        @(negedge tck);
        #0.5 trst_n = 1;
        check("R1");
        step(0, 0, "R1");
        scan_dr(32, 0, "R1");
        for (int i = 0; i < 600; i++) step(1'(($urandom % 3) == 0), 1'($urandom), "R4");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule